// File: doc/BRIEF.md
# Ring-Buffered Deflection Router Core

This block is the switching core of a buffered deflection router. Every output port owns a small group of flit slots. The groups are linked in a ring. On every clock each port looks only at its own group and at the flit that arrives on that port, and it sends at most one flit. The flit it sends is one for which the port is productive, or, when the group would otherwise overflow, the least important flit that cannot use the port. Whatever is not sent is re-ranked. The first half of the ranking stays at the port. The second half, including empty slots, moves one port onward around the ring. All groups move on the same edge, so a waiting flit travels around the router until it reaches a port that brings it closer to its destination.

An upstream stage supplies each flit with a priority and a per-port productive mask. Computing these, ejection and link timing belong to other blocks. The departing flit of each port is registered.

Top module: `rdr_ring_router`

## Requirements
- R1: While `rst` is high, every output valid and every stored slot is cleared. After reset no flit stored before the reset ever appears on an output.
- R2: A flit is `{mask[NPORTS-1:0], prio[PRIO_W-1:0], data[DATA_W-1:0]}`, with the data in the low bits. Mask bit p set means port p is productive for the flit. If any candidate at port p (its arriving flit or a stored slot) has mask bit p set, port p sends the productive candidate with the highest `prio`, even over non-productive candidates of higher priority.
- R3: When candidates have equal ranking keys, the arriving flit wins over slot 0, and a lower slot index wins over a higher one.
- R4: If no candidate at a port is productive and the group does not overflow, the port sends nothing and keeps the arriving flit.
- R5: Overflow means that all NSLOT slots are valid and a flit arrives. With no productive candidate, the port then sends the non-productive candidate with the lowest `prio`.
- R6: The candidates that remain are ranked with productive flits first (highest `prio` first) and then non-productive flits (lowest `prio` first), followed by empty slots. The first NSLOT/2 positions stay in the group. The other positions move into the same positions of the group of port (p+1) mod NPORTS on the same clock edge.
- R7: No flit is lost or duplicated. Stored flits plus sent flits always equal stored flits plus arriving flits of the previous cycle.
- R8: A flit sent on the edge that samples its port's candidates appears on `out_valid`/`out_flit` right after that edge. In a cycle with no send, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NPORTS | Arriving flit valid, one bit per port |
| in_flit | input | NPORTS*(DATA_W+PRIO_W+NPORTS) | Arriving flits, port p at slice p |
| out_valid | output | NPORTS | Departing flit valid, registered |
| out_flit | output | NPORTS*(DATA_W+PRIO_W+NPORTS) | Departing flits, registered |

## Verification
The bench builds the block with its defaults: four ports, four slots per port (a half-group of two), 8-bit data and 4-bit priority. This is the smallest shape in which three flits fed into one port push the highest-priority non-productive flit into the rotating half. With it, a flit can be followed cycle by cycle into its neighbour's group and out of the neighbour's port. Feeding non-productive flits into all four ports for four cycles fills every group completely through the ring itself. One further arrival then forces the overflow deflection, with both a lower-priority and a higher-priority newcomer.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

  localparam int unsigned KEY_MAX_W = 32;

  // True when candidate a ranks ahead of candidate b: larger key, or equal key and lower index.
  function automatic logic cand_wins(input logic [KEY_MAX_W-1:0] key_a,
                                     input logic [KEY_MAX_W-1:0] key_b,
                                     input int idx_a,
                                     input int idx_b);
    return (key_a > key_b) || ((key_a == key_b) && (idx_a < idx_b));
  endfunction

endpackage

// File: rtl/rdr_rank_arb.sv
module rdr_rank_arb
  import rdr_pkg::*;
#(
  parameter int NPORTS  = 4,
  parameter int NSLOT   = 4,
  parameter int DATA_W  = 8,
  parameter int PRIO_W  = 4,
  parameter int PORT_ID = 0,
  localparam int FLIT_W = DATA_W + PRIO_W + NPORTS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    arr_v,
  input  logic [FLIT_W-1:0]       arr_f,
  input  logic [NSLOT-1:0]        slot_v,
  input  logic [NSLOT*FLIT_W-1:0] slot_f,
  output logic                    send_v,
  output logic [FLIT_W-1:0]       send_f,
  output logic [NSLOT-1:0]        ord_v,
  output logic [NSLOT*FLIT_W-1:0] ord_f
);

  localparam int NCAND    = NSLOT + 1;
  localparam int KEY_W    = PRIO_W + 1;
  localparam int MASK_LSB = DATA_W + PRIO_W;

  // Candidate 0 is the arriving flit, candidates 1..NSLOT are the slots.
  logic              cv    [NCAND];
  logic [FLIT_W-1:0] cf    [NCAND];
  logic              cprod [NCAND];
  logic [KEY_W-1:0]  ckey  [NCAND];
  int                rank  [NCAND];
  int                nvalid;
  logic              top_prod;
  logic              overflow;
  logic              any_prod;

  always_comb begin : gather
    cv[0] = arr_v;
    cf[0] = arr_f;
    for (int k = 0; k < NSLOT; k++) begin
      cv[k+1] = slot_v[k];
      cf[k+1] = slot_f[k*FLIT_W +: FLIT_W];
    end
  end

  // Productive flits order by priority descending, others by priority ascending.
  always_comb begin : keys
    for (int i = 0; i < NCAND; i++) begin
      cprod[i] = cf[i][MASK_LSB + PORT_ID];
      ckey[i]  = cprod[i] ? {1'b1, cf[i][DATA_W +: PRIO_W]}
                          : {1'b0, ~cf[i][DATA_W +: PRIO_W]};
    end
  end

  always_comb begin : ranking
    nvalid = 0;
    for (int i = 0; i < NCAND; i++) nvalid = nvalid + int'(cv[i]);
    for (int i = 0; i < NCAND; i++) begin
      rank[i] = cv[i] ? 0 : nvalid;
      for (int j = 0; j < NCAND; j++) begin
        if (j != i) begin
          if (cv[i]) begin
            if (cv[j] && cand_wins(KEY_MAX_W'(ckey[j]), KEY_MAX_W'(ckey[i]), j, i))
              rank[i] = rank[i] + 1;
          end else if (!cv[j] && (j < i)) begin
            rank[i] = rank[i] + 1;
          end
        end
      end
    end
  end

  always_comb begin : select
    send_f   = '0;
    top_prod = 1'b0;
    any_prod = 1'b0;
    for (int i = 0; i < NCAND; i++) begin
      any_prod = any_prod | (cv[i] & cprod[i]);
      if (cv[i] && (rank[i] == 0)) begin
        send_f   = cf[i];
        top_prod = cprod[i];
      end
    end
    overflow = (nvalid == NCAND);
    send_v   = (nvalid > 0) && (top_prod || overflow);
  end

  always_comb begin : compact
    ord_v = '0;
    ord_f = '0;
    for (int i = 0; i < NCAND; i++) begin
      if (!(send_v && (rank[i] == 0))) begin
        for (int k = 0; k < NSLOT; k++) begin
          if ((rank[i] - int'(send_v)) == k) begin
            ord_v[k]                    = cv[i];
            ord_f[k*FLIT_W +: FLIT_W]   = cf[i];
          end
        end
      end
    end
  end

  logic              sent_prod;
  logic [PRIO_W-1:0] sent_prio;
  logic              slots_full;
  assign sent_prod  = send_f[MASK_LSB + PORT_ID];
  assign sent_prio  = send_f[DATA_W +: PRIO_W];
  assign slots_full = &slot_v;

  assert_prod_first_R2: assert property (@(posedge clk) disable iff (rst)
    any_prod |-> (send_v && sent_prod));

  assert_hold_room_R4: assert property (@(posedge clk) disable iff (rst)
    (!any_prod && !(arr_v && slots_full)) |-> !send_v);

  assert_overflow_send_R5: assert property (@(posedge clk) disable iff (rst)
    (arr_v && slots_full) |-> send_v);

  assert_deflect_lowest_R5: assert property (@(posedge clk) disable iff (rst)
    (send_v && !sent_prod && arr_v) |-> (sent_prio <= arr_f[DATA_W +: PRIO_W]));

  assert_group_fits_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |-> (($countones(ord_v) + int'(send_v)) == ($countones(slot_v) + int'(arr_v))));

endmodule

// File: rtl/rdr_ring_store.sv
module rdr_ring_store #(
  parameter int NPORTS = 4,
  parameter int NSLOT  = 4,
  parameter int FLIT_W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NPORTS*NSLOT-1:0]        ord_v,
  input  logic [NPORTS*NSLOT*FLIT_W-1:0] ord_f,
  output logic [NPORTS*NSLOT-1:0]        slot_v,
  output logic [NPORTS*NSLOT*FLIT_W-1:0] slot_f
);

  localparam int HALF = NSLOT / 2;

  for (genvar p = 0; p < NPORTS; p++) begin : g_grp
    localparam int PREV = (p == 0) ? NPORTS - 1 : p - 1;
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      // Upper half of the ranking stays; lower half arrives from the previous port.
      localparam int SRC = ((k < HALF) ? p : PREV) * NSLOT + k;
      localparam int DST = p * NSLOT + k;

      always_ff @(posedge clk) begin
        if (rst) slot_v[DST] <= 1'b0;
        else     slot_v[DST] <= ord_v[SRC];
      end

      always_ff @(posedge clk) begin
        slot_f[DST*FLIT_W +: FLIT_W] <= ord_f[SRC*FLIT_W +: FLIT_W];
      end
    end
  end

endmodule

// File: rtl/rdr_ring_router.sv
module rdr_ring_router #(
  parameter int NPORTS = 4,
  parameter int NSLOT  = 4,
  parameter int DATA_W = 8,
  parameter int PRIO_W = 4,
  localparam int FLIT_W = DATA_W + PRIO_W + NPORTS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORTS-1:0]        in_valid,
  input  logic [NPORTS*FLIT_W-1:0] in_flit,
  output logic [NPORTS-1:0]        out_valid,
  output logic [NPORTS*FLIT_W-1:0] out_flit
);

  localparam int GRP_W = NSLOT * FLIT_W;

  logic [NPORTS*NSLOT-1:0]  slot_v;
  logic [NPORTS*GRP_W-1:0]  slot_f;
  logic [NPORTS*NSLOT-1:0]  ord_v;
  logic [NPORTS*GRP_W-1:0]  ord_f;
  logic [NPORTS-1:0]        send_v;
  logic [NPORTS*FLIT_W-1:0] send_f;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    rdr_rank_arb #(
      .NPORTS (NPORTS),
      .NSLOT  (NSLOT),
      .DATA_W (DATA_W),
      .PRIO_W (PRIO_W),
      .PORT_ID(p)
    ) u_arb (
      .clk   (clk),
      .rst   (rst),
      .arr_v (in_valid[p]),
      .arr_f (in_flit[p*FLIT_W +: FLIT_W]),
      .slot_v(slot_v[p*NSLOT +: NSLOT]),
      .slot_f(slot_f[p*GRP_W +: GRP_W]),
      .send_v(send_v[p]),
      .send_f(send_f[p*FLIT_W +: FLIT_W]),
      .ord_v (ord_v[p*NSLOT +: NSLOT]),
      .ord_f (ord_f[p*GRP_W +: GRP_W])
    );
  end

  rdr_ring_store #(
    .NPORTS(NPORTS),
    .NSLOT (NSLOT),
    .FLIT_W(FLIT_W)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .ord_v (ord_v),
    .ord_f (ord_f),
    .slot_v(slot_v),
    .slot_f(slot_f)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= '0;
    else     out_valid <= send_v;
  end

  always_ff @(posedge clk) begin
    out_flit <= send_f;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> ((out_valid == '0) && (slot_v == '0)));

  assert_conserve_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($countones(slot_v) ==
              $past($countones(slot_v) + $countones(in_valid) - $countones(send_v))));

endmodule

// File: tb/sim_rdr_ring_router.sv
module sim_rdr_ring_router;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NS = 4;
  localparam int DW = 8;
  localparam int PW = 4;
  localparam int FW = DW + PW + NP;

  logic             clk;
  logic             rst;
  logic [NP-1:0]    in_valid;
  logic [NP*FW-1:0] in_flit;
  logic [NP-1:0]    out_valid;
  logic [NP*FW-1:0] out_flit;

  int checks = 0;
  int errors = 0;

  rdr_ring_router #(.NPORTS(NP), .NSLOT(NS), .DATA_W(DW), .PRIO_W(PW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
    .out_valid(out_valid), .out_flit(out_flit)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [FW-1:0] mk(input logic [NP-1:0] m, input logic [PW-1:0] pr,
                                       input logic [DW-1:0] d);
    return {m, pr, d};
  endfunction

  function automatic logic [FW-1:0] outf(input int p);
    return out_flit[p*FW +: FW];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = '0;
    in_flit  = '0;
  endtask

  task automatic drive(input int p, input logic [FW-1:0] f);
    in_valid[p]          = 1'b1;
    in_flit[p*FW +: FW]  = f;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle();
    tick();
    tick();
    rst = 1'b0;
  endtask

  localparam logic [FW-1:0] F1 = {4'b0010, 4'd5, 8'h11};
  localparam logic [FW-1:0] F2 = {4'b0010, 4'd6, 8'h22};
  localparam logic [FW-1:0] F3 = {4'b0010, 4'd7, 8'h33};

  // Three flits non-productive at port 0; F3 ends up in the rotating half.
  task automatic preload();
    idle(); drive(0, F1); tick();
    idle(); drive(0, F2); tick();
    idle(); drive(0, F3); tick();
    idle();
  endtask

  task automatic t_reset();
    do_reset();
    chk(out_valid == '0, "R1 outputs idle after reset", 32'(out_valid), 0);
    preload();
    do_reset();
    tick(); tick();
    chk(out_valid == '0, "R1 stored flits cleared by reset", 32'(out_valid), 0);
  endtask

  task automatic t_direct();
    logic [FW-1:0] f;
    do_reset();
    f = mk(4'b0100, 4'd3, 8'hA5);
    drive(2, f); tick(); idle();
    chk(out_valid == 4'b0100, "R8 productive arrival leaves next cycle", 32'(out_valid), 32'h4);
    chk(outf(2) == f, "R2 departing flit content", 32'(outf(2)), 32'(f));
    tick();
    chk(out_valid == '0, "R8 no send gives idle output", 32'(out_valid), 0);
  endtask

  task automatic t_rotate();
    do_reset();
    preload();
    chk(out_valid == '0, "R4 non-productive flits held", 32'(out_valid), 0);
    tick();
    chk(out_valid == 4'b0010, "R6 rotated flit sent at next port", 32'(out_valid), 32'h2);
    chk(outf(1) == F3, "R6 highest-prio non-productive rotated", 32'(outf(1)), 32'(F3));
  endtask

  task automatic t_tie();
    logic [FW-1:0] a;
    int cnt;
    do_reset();
    preload();
    a = mk(4'b0010, 4'd7, 8'h5A);
    drive(1, a); tick(); idle();
    chk(out_valid == 4'b0010 && outf(1) == a, "R3 arrival wins equal key", 32'(outf(1)), 32'(a));
    tick();
    chk(out_valid == 4'b0010 && outf(1) == F3, "R2 stored productive sent later",
        32'(outf(1)), 32'(F3));
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      cnt += $countones(out_valid);
    end
    chk(cnt == 0, "R7 no duplicate departures", 32'(cnt), 0);
  endtask

  task automatic t_prio();
    logic [FW-1:0] b;
    logic [FW-1:0] c;
    do_reset();
    preload();
    b = mk(4'b0010, 4'd6, 8'h6B);
    c = mk(4'b0001, 4'd0, 8'h0C);
    drive(1, b); drive(0, c); tick(); idle();
    chk(out_valid == 4'b0011, "R2 both ports send", 32'(out_valid), 32'h3);
    chk(outf(1) == F3, "R2 higher-prio stored productive first", 32'(outf(1)), 32'(F3));
    chk(outf(0) == c, "R2 productive beats higher-prio deflectable", 32'(outf(0)), 32'(c));
    tick();
    chk(out_valid == 4'b0010 && outf(1) == b, "R2 lower-prio productive follows",
        32'(outf(1)), 32'(b));
  endtask

  task automatic t_overflow();
    logic [FW-1:0] lo;
    logic [FW-1:0] hi;
    do_reset();
    for (int c = 1; c <= 4; c++) begin
      idle();
      for (int p = 0; p < NP; p++) drive(p, mk(4'b0000, 4'd8, 8'(c*16 + p)));
      tick();
      chk(out_valid == '0, "R4 filling groups sends nothing", 32'(out_valid), 0);
    end
    idle();
    lo = mk(4'b0000, 4'd2, 8'hE0);
    drive(0, lo); tick(); idle();
    chk(out_valid == 4'b0001, "R5 overflow deflects at port 0", 32'(out_valid), 32'h1);
    chk(outf(0) == lo, "R5 lowest-prio arrival deflected", 32'(outf(0)), 32'(lo));
    hi = mk(4'b0000, 4'd15, 8'hE1);
    drive(1, hi); tick(); idle();
    chk(out_valid == 4'b0010, "R5 overflow deflects at port 1", 32'(out_valid), 32'h2);
    chk(outf(1)[DW +: PW] == 4'd8, "R5 lowest-prio stored flit deflected",
        32'(outf(1)[DW +: PW]), 32'h8);
    chk(outf(1)[DW-1:0] != 8'hE1, "R5 high-prio arrival kept", 32'(outf(1)[DW-1:0]), 32'hE1);
  endtask

  initial begin
    rst = 1'b1;
    idle();
    t_reset();
    t_direct();
    t_rotate();
    t_tie();
    t_prio();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule